// File: doc/BRIEF.md
# Configurable-Frame UART Transmitter

This block turns one data word per request into an asynchronous serial frame on a single output line. A frame starts with one low start bit and carries 5 to 8 data bits, least significant first. An optional parity bit, odd or even, comes next. The frame ends with a high stop period of 0.5, 1, 1.5 or 2 bit times. Bit timing comes from an external oversampling enable that pulses sixteen times per bit. The block has no baud generator of its own.

A producer offers a word together with a framing selection on a valid/ready handshake. Ready is high only while the line is idle. The word and the framing fields are captured on the clock where valid and ready are both high. Those inputs may change freely from then until the frame is over. Ready returns on the clock after the last stop tick. A producer that holds valid high therefore gets frames back to back with no idle ticks between them.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1, `in_ready` is 1 and `tx_busy` is 0.
- R2: A handshake (`in_valid` and `in_ready` high at a rising clock edge) starts a frame. From the next cycle `tx_line` is 0 (start bit), `in_ready` is 0 and `tx_busy` is 1. The start bit lasts 16 `tick_en` pulses.
- R3: `cfg_len` selects the data length: 00=5, 01=6, 10=7, 11=8 bits. Data bits follow the start bit least significant first, each lasting 16 ticks.
- R4: Input bits at or above the selected length never appear on the line and do not affect parity.
- R5: With `cfg_par_en`=1, one parity bit of 16 ticks follows the last data bit. With `cfg_par_en`=0, the stop period follows the last data bit directly.
- R6: `cfg_par_odd`=1 makes the total number of ones in the data bits plus the parity bit odd. `cfg_par_odd`=0 makes that total even.
- R7: The stop period drives `tx_line` high for 8, 16, 24 or 32 ticks for `cfg_stop` codes 00, 01, 10 and 11.
- R8: Changes to `in_data` and to the configuration inputs after the handshake do not alter the frame in progress.
- R9: `in_ready` stays 0 through the last stop tick and is 1 on the clock after it. A handshake on that clock starts the next frame with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Oversampling enable, 16 pulses per bit |
| in_data | input | 8 | Word to send; only the selected low bits are used |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Transmitter is idle and accepts a word |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop | input | 2 | Stop length code in half-bit steps |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | A frame is in progress |

## Verification
Line, ready and busy are registered together. They change on the clock edge that consumes the handshake or the closing tick of a slot. The bench generates every tick itself and counts them from the handshake. It samples `tx_line` on the falling edge where the eighth tick of each bit slot is presented, which is the middle of the slot. It samples the stop level at the fourth stop tick. Ready is checked low on the falling edge that presents the final stop tick and high on the falling edge right after it is consumed. The frame length is therefore pinned to the exact tick with no tolerance.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;

  localparam int unsigned MAX_WORD = 8;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } tx_phase_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop_code;
  } tx_cfg_t;

  // Number of data bits for a length code.
  function automatic logic [3:0] word_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // Stop period length in oversampling ticks (half-bit steps).
  function automatic int unsigned stop_ticks(input logic [1:0] code,
                                             input int unsigned tpb);
    return (tpb / 2) * (int'(code) + 1);
  endfunction

  // Parity over the used bits only; odd selection seeds the fold with 1.
  function automatic logic frame_parity(input logic [MAX_WORD-1:0] w,
                                        input logic [1:0] code,
                                        input logic odd);
    logic acc;
    acc = odd;
    for (int i = 0; i < MAX_WORD; i++) begin
      if (i < int'(word_bits(code))) acc = acc ^ w[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/tx_tick_ctr.sv
module tx_tick_ctr #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [CNT_W:0]   limit,
  output logic             slot_done
);
  logic [CNT_W-1:0] cnt_q;

  assign slot_done = run && tick_en && ({1'b0, cnt_q} == (limit - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || slot_done) begin
      cnt_q <= '0;
    end else if (run && tick_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tx_word_shifter.sv
module tx_word_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] load_word,
  output logic         next_lsb
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = load_word;
    else if (shift) sr_d = sr_q >> 1;
  end

  assign next_lsb = sr_d[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/tx_phase_seq.sv
module tx_phase_seq
  import uart_frame_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [MAX_WORD-1:0] in_data,
  input  tx_cfg_t             cfg_in,
  input  logic                slot_done,
  input  logic                next_lsb,
  output tx_phase_e           phase_q,
  output tx_cfg_t             cfg_q,
  output logic                hs_fire,
  output logic                shift,
  output logic                frame_end,
  output logic [CNT_W:0]      tick_limit,
  output logic                line_q
);
  localparam int unsigned IDX_W = 3;

  tx_phase_e        phase_d;
  logic [IDX_W-1:0] bit_idx_q;
  logic             par_q;
  logic             data_last;
  logic             line_d;

  assign hs_fire   = (phase_q == PH_IDLE) && in_valid;
  assign data_last = ({1'b0, bit_idx_q} == (word_bits(cfg_q.len_code) - 4'd1));
  assign shift     = slot_done && (phase_q == PH_DATA);
  assign frame_end = slot_done && (phase_q == PH_STOP);

  always_comb begin
    if (phase_q == PH_STOP)
      tick_limit = (CNT_W+1)'(stop_ticks(cfg_q.stop_code, TICKS_PER_BIT));
    else
      tick_limit = (CNT_W+1)'(TICKS_PER_BIT);
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (hs_fire)   phase_d = PH_START;
      PH_START: if (slot_done) phase_d = PH_DATA;
      PH_DATA:  if (slot_done && data_last)
                  phase_d = cfg_q.par_en ? PH_PAR : PH_STOP;
      PH_PAR:   if (slot_done) phase_d = PH_STOP;
      PH_STOP:  if (slot_done) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (phase_d)
      PH_START: line_d = 1'b0;
      PH_DATA:  line_d = next_lsb;
      PH_PAR:   line_d = par_q;
      default:  line_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cfg_q     <= '0;
      bit_idx_q <= '0;
      par_q     <= 1'b0;
      line_q    <= 1'b1;
    end else begin
      phase_q <= phase_d;
      line_q  <= line_d;
      if (hs_fire) begin
        cfg_q     <= cfg_in;
        par_q     <= frame_parity(in_data, cfg_in.len_code, cfg_in.par_odd);
        bit_idx_q <= '0;
      end else if (shift) begin
        bit_idx_q <= bit_idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  output logic       tx_line,
  output logic       tx_busy
);
  localparam int unsigned CNT_W = $clog2(2 * TICKS_PER_BIT);

  tx_cfg_t        cfg_in, cfg_q;
  tx_phase_e      phase_q;
  logic           hs_fire, shift, frame_end, slot_done, next_lsb;
  logic [CNT_W:0] tick_limit;
  logic           stop_phase;

  assign cfg_in = '{len_code: cfg_len, par_en: cfg_par_en,
                    par_odd: cfg_par_odd, stop_code: cfg_stop};

  tx_phase_seq #(.TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_in(cfg_in), .slot_done(slot_done), .next_lsb(next_lsb),
    .phase_q(phase_q), .cfg_q(cfg_q), .hs_fire(hs_fire), .shift(shift),
    .frame_end(frame_end), .tick_limit(tick_limit), .line_q(tx_line)
  );

  tx_tick_ctr #(.CNT_W(CNT_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(phase_q != PH_IDLE), .tick_en(tick_en),
    .restart(hs_fire), .limit(tick_limit), .slot_done(slot_done)
  );

  tx_word_shifter #(.W(MAX_WORD)) shf_i (
    .clk(clk), .rst_n(rst_n), .load(hs_fire), .shift(shift),
    .load_word(in_data), .next_lsb(next_lsb)
  );

  assign stop_phase = (phase_q == PH_STOP);
  assign in_ready   = (phase_q == PH_IDLE);
  assign tx_busy    = (phase_q != PH_IDLE);
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk
  import uart_frame_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input logic    clk,
  input logic    rst_n,
  input logic    tick_en,
  input logic    tx_line,
  input logic    tx_busy,
  input logic    in_ready,
  input logic    hs_fire,
  input logic    frame_end,
  input logic    stop_phase,
  input tx_cfg_t cfg_q
);
  int unsigned stop_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stop_cnt <= 0;
    else if (!stop_phase)      stop_cnt <= 0;
    else if (tick_en)          stop_cnt <= stop_cnt + 1;
  end

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fire |=> (!tx_line && !in_ready));

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_line);

  a_r7_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    stop_phase |-> tx_line);

  a_r7_stop_len: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (stop_cnt + 1 == stop_ticks(cfg_q.stop_code, TICKS_PER_BIT)));

  a_r9_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (in_ready && tx_line));

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy)) |-> $stable(cfg_q));
endmodule

bind uart_frame_tx uart_frame_tx_chk #(.TICKS_PER_BIT(TICKS_PER_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tx_line(tx_line),
  .tx_busy(tx_busy), .in_ready(in_ready), .hs_fire(hs_fire),
  .frame_end(frame_end), .stop_phase(stop_phase), .cfg_q(cfg_q)
);

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] cfg_len = '0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = '0;
  logic       tx_line;
  logic       tx_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
    .tx_line(tx_line), .tx_busy(tx_busy)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Bench parity: count ones among the used bits, then pick the bit.
  function automatic logic bench_par(input logic [7:0] w, input int nd,
                                     input bit odd);
    int ones = 0;
    for (int i = 0; i < nd; i++) if (w[i]) ones++;
    if (odd) return (ones % 2 == 0);
    return (ones % 2 == 1);
  endfunction

  task automatic send_frame(input logic [7:0] w, input logic [1:0] lc,
                            input bit pe, input bit po, input logic [1:0] sc,
                            input int tp);
    logic exp_bits [0:11];
    int nd, nb, tt;
    nd = int'(lc) + 5;
    nb = 1 + nd + (pe ? 1 : 0);
    tt = 16 * nb + 8 * (int'(sc) + 1);
    exp_bits[0] = 1'b0;
    for (int i = 0; i < nd; i++) exp_bits[1+i] = w[i];
    if (pe) exp_bits[1+nd] = bench_par(w, nd, po);

    in_data = w; cfg_len = lc; cfg_par_en = pe; cfg_par_odd = po;
    cfg_stop = sc; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    // R8: scramble everything once the word has been taken.
    in_data = 8'($urandom); cfg_len = 2'($urandom); cfg_par_en = 1'($urandom);
    cfg_par_odd = 1'($urandom); cfg_stop = 2'($urandom);
    chk("R2 start low after handshake", tx_line, 1'b0);
    chk("R2 busy during frame", tx_busy, 1'b1);

    for (int j = 1; j <= tt; j++) begin
      tick_en = 1'b1;
      if (j <= 16 * nb && ((j - 1) % 16) == 7) begin
        int s = (j - 1) / 16;
        if (s == 0)           chk("R2 start bit", tx_line, exp_bits[s]);
        else if (s <= nd)     chk("R3/R4/R8 data bit", tx_line, exp_bits[s]);
        else                  chk("R5/R6 parity bit", tx_line, exp_bits[s]);
      end
      if (j == 16 * nb + 4) chk("R5/R7 stop level", tx_line, 1'b1);
      if (j == tt) begin
        chk("R9 ready low at last stop tick", in_ready, 1'b0);
        chk("R7 line high at last stop tick", tx_line, 1'b1);
      end
      @(negedge clk);
      tick_en = 1'b0;
      if (j != tt) repeat (tp - 1) @(negedge clk);
    end
    chk("R9 ready after stop", in_ready, 1'b1);
    chk("R1 idle busy low", tx_busy, 1'b0);
    chk("R1 idle line high", tx_line, 1'b1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk);
    chk("R1 reset line", tx_line, 1'b1);
    chk("R1 reset ready", in_ready, 1'b1);
    chk("R1 reset busy", tx_busy, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed: every length and stop code, both parities, back to back.
    for (int k = 0; k < 4; k++)
      send_frame(8'hA5 ^ 8'(k), 2'(k), 1'b1, k[0], 2'(k), 1);
    send_frame(8'hE0, 2'b00, 1'b1, 1'b1, 2'b00, 2);   // R4: upper bits set
    send_frame(8'h1F, 2'b00, 1'b1, 1'b0, 2'b01, 3);   // R4/R6 even
    send_frame(8'hFF, 2'b11, 1'b0, 1'b0, 2'b11, 2);   // R5 no parity
    send_frame(8'h00, 2'b11, 1'b1, 1'b1, 2'b00, 1);   // R6 odd zero word

    for (int r = 0; r < 50; r++)
      send_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), 1 + int'($urandom % 3));

    repeat (4) @(negedge clk);
    chk("R1 long idle line", tx_line, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule